// File: doc/BRIEF.md
# USB Packet Receiver: SYNC Detection, NRZI Decoding and Byte Assembly

This block sits behind a clock-recovery stage that already turns the USB differential pair into one line state per bit time. Each time `sym_en_i` is high the block takes one symbol (J, K or SE0) from `sym_i`. While no packet is in progress it looks for the packet preamble: an idle (J) line followed by an alternating K/J run that closes with two K symbols. The second K of that closing pair is the anchor for the packet. The symbol that follows it carries bit 0 of the first byte, and the anchor K is also the NRZI reference level for that bit.

After the anchor the block NRZI-decodes every symbol and removes the zero bits that the transmitter stuffed in after long runs of ones. It shifts the decoded bits into bytes least significant bit first and pulses `byte_vld_o` for each complete byte, with `byte_sop_o` on the first byte of a packet. Two SE0 symbols in a row end the packet. A run of ones with no stuffed bit after it drops the packet. In both cases the block goes back to searching for the next preamble. CRC, PID checks and transaction handling belong to later stages.

Top module: `usb_sync_rx`

## Requirements
- R1: `sym_i` encodes line state as 2'b01 = J (idle), 2'b10 = K, and 2'b00 or 2'b11 = SE0. A packet starts only when at least IDLE_MIN (default 2) consecutive J symbols are followed by K J K J K J K K. None of those preamble symbols is delivered as data, so the first byte reported holds the first bit after the final K.
- R2: A shortened preamble is also accepted. After the idle J symbols, any alternating run that starts with K, has at least MIN_ALT (default 3) symbols and ends on K, then one more K, starts a packet. The shortest accepted form is K J K K after idle.
- R3: No output pulses at all result from a preamble with fewer than IDLE_MIN idle J symbols before it, from an alternating run shorter than MIN_ALT, or from SE0 symbols while no packet is in progress.
- R4: Packet symbols are NRZI-decoded against the preceding symbol. The first one is compared with the final K of the preamble. The same level decodes as 1 and a change of level decodes as 0.
- R5: Decoded bits fill each byte from bit 0 upward. `byte_vld_o` pulses for one clock per completed byte with the byte on `byte_o`. `byte_sop_o` is high with it only for the first byte of a packet.
- R6: After STUFF_RUN (default 6) consecutive decoded 1s, counted from the first packet bit, a following 0 is discarded and is not placed in any byte.
- R7: If the bit after STUFF_RUN consecutive 1s is also 1, `err_stuff_o` pulses once. No byte or end-of-packet pulse follows, and the packet is dropped.
- R8: Two consecutive SE0 symbols in a packet produce one `eop_o` pulse. `err_align_o` pulses in the same cycle when the number of data bits received is not a whole number of bytes, and the partial byte is discarded.
- R9: After an end of packet or a stuffing error the block searches for a new preamble, and the next packet is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_en_i | input | 1 | One-cycle strobe per received bit time |
| sym_i | input | 2 | Line state for this bit time (01 J, 10 K, 00/11 SE0) |
| byte_vld_o | output | 1 | Completed byte strobe |
| byte_o | output | DATA_W | Received byte, bit 0 received first |
| byte_sop_o | output | 1 | First byte of the packet, valid with byte_vld_o |
| eop_o | output | 1 | End-of-packet pulse |
| err_align_o | output | 1 | End of packet with a partial byte |
| err_stuff_o | output | 1 | Missing stuffed zero; packet dropped |

## Verification
The hardest case to reach from the ports is the stuffing boundary. The driver must produce exactly six ones followed by either a 0 or a 1 at the decoded level, and that depends on the NRZI level that the preamble anchor set up. The bench therefore encodes frames with its own NRZI transmitter, which starts from the anchor K. Stuffing can be switched off in that transmitter, so one frame can carry a seventh one that is never broken. Back-to-back frames, preambles with too little idle before them, and frames with a bit count that is not a whole number of bytes exercise the return to searching and the alignment flag.

// File: rtl/usb_rx_pkg.sv
package usb_rx_pkg;
   typedef enum logic [1:0] {
      SYM_SE0 = 2'b00,
      SYM_J   = 2'b01,
      SYM_K   = 2'b10,
      SYM_SE1 = 2'b11
   } line_sym_e;

   typedef enum logic {
      MODE_HUNT = 1'b0,
      MODE_RECV = 1'b1
   } rx_mode_e;
endpackage

// File: rtl/usb_sync_hunt.sv
module usb_sync_hunt #(
   parameter int IDLE_MIN = 2,
   parameter int MIN_ALT  = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       arm_i,
   input  logic       en_i,
   input  logic [1:0] sym_i,
   output logic       hit_o
);
   import usb_rx_pkg::*;

   localparam int IW = $clog2(IDLE_MIN + 1);
   localparam int AW = $clog2(MIN_ALT + 1);

   initial begin
      assert (IDLE_MIN >= 1) else $error("IDLE_MIN must be at least 1");
      assert (MIN_ALT >= 3 && MIN_ALT <= 7 && (MIN_ALT % 2) == 1)
         else $error("MIN_ALT must be odd and in 3..7");
   end

   logic [IW-1:0] idle_q;
   logic [AW-1:0] alt_q;
   logic          in_alt_q;
   logic          last_k_q;
   logic          is_j, is_k, alternates;

   assign is_j       = (sym_i == SYM_J);
   assign is_k       = (sym_i == SYM_K);
   assign alternates = in_alt_q && ((is_k && !last_k_q) || (is_j && last_k_q));
   assign hit_o      = arm_i && en_i && in_alt_q && is_k && last_k_q &&
                       (alt_q >= AW'(MIN_ALT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle_q   <= '0;
         alt_q    <= '0;
         in_alt_q <= 1'b0;
         last_k_q <= 1'b0;
      end else if (!arm_i) begin
         idle_q   <= '0;
         alt_q    <= '0;
         in_alt_q <= 1'b0;
         last_k_q <= 1'b0;
      end else if (en_i) begin
         if (!in_alt_q) begin
            if (is_j) begin
               if (idle_q != IW'(IDLE_MIN)) idle_q <= idle_q + IW'(1);
            end else if (is_k && idle_q == IW'(IDLE_MIN)) begin
               in_alt_q <= 1'b1;
               alt_q    <= AW'(1);
               last_k_q <= 1'b1;
               idle_q   <= '0;
            end else begin
               idle_q <= '0;
            end
         end else if (alternates) begin
            if (alt_q != AW'(MIN_ALT)) alt_q <= alt_q + AW'(1);
            last_k_q <= ~last_k_q;
         end else begin
            in_alt_q <= 1'b0;
            alt_q    <= '0;
            idle_q   <= is_j ? IW'(1) : '0;
         end
      end
   end

   // R2
   alt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alt_q <= AW'(MIN_ALT));
endmodule

// File: rtl/usb_nrzi_unstuff.sv
module usb_nrzi_unstuff #(
   parameter int STUFF_RUN = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic en_i,
   input  logic level_i,
   output logic bit_vld_o,
   output logic bit_o,
   output logic stuff_err_o
);
   localparam int CW = $clog2(STUFF_RUN + 1);

   initial begin
      assert (STUFF_RUN >= 1) else $error("STUFF_RUN must be at least 1");
   end

   logic          prev_q;
   logic [CW-1:0] ones_q;
   logic          raw, at_limit;

   assign raw         = (level_i == prev_q);
   assign at_limit    = (ones_q == CW'(STUFF_RUN));
   assign bit_vld_o   = en_i && !at_limit;
   assign bit_o       = raw;
   assign stuff_err_o = en_i && at_limit && raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         ones_q <= '0;
      end else if (load_i) begin
         prev_q <= 1'b1;
         ones_q <= '0;
      end else if (en_i) begin
         prev_q <= level_i;
         if (at_limit || !raw) ones_q <= '0;
         else                  ones_q <= ones_q + CW'(1);
      end
   end

   // R6
   ones_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ones_q <= CW'(STUFF_RUN));
endmodule

// File: rtl/usb_byte_pack.sv
module usb_byte_pack #(
   parameter int DATA_W    = 8,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              bit_vld_i,
   input  logic              bit_i,
   input  logic              end_i,
   input  logic              abort_i,
   output logic              byte_vld_o,
   output logic [DATA_W-1:0] byte_o,
   output logic              sop_o,
   output logic              eop_o,
   output logic              err_align_o,
   output logic              err_stuff_o
);
   localparam int BW = $clog2(DATA_W);

   initial begin
      assert (DATA_W >= 2) else $error("DATA_W must be at least 2");
   end

   logic [DATA_W-1:0] sr_q, sr_nxt;
   logic [BW-1:0]     idx_q;
   logic              first_q, last;

   generate
      if (LSB_FIRST) begin : g_lsb
         assign sr_nxt = {bit_i, sr_q[DATA_W-1:1]};
      end else begin : g_msb
         assign sr_nxt = {sr_q[DATA_W-2:0], bit_i};
      end
   endgenerate

   assign last = (idx_q == BW'(DATA_W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q        <= '0;
         idx_q       <= '0;
         first_q     <= 1'b0;
         byte_vld_o  <= 1'b0;
         byte_o      <= '0;
         sop_o       <= 1'b0;
         eop_o       <= 1'b0;
         err_align_o <= 1'b0;
         err_stuff_o <= 1'b0;
      end else begin
         byte_vld_o  <= 1'b0;
         sop_o       <= 1'b0;
         eop_o       <= 1'b0;
         err_align_o <= 1'b0;
         err_stuff_o <= 1'b0;
         if (start_i) begin
            idx_q   <= '0;
            first_q <= 1'b1;
         end else if (abort_i) begin
            err_stuff_o <= 1'b1;
            idx_q       <= '0;
         end else if (end_i) begin
            eop_o       <= 1'b1;
            err_align_o <= (idx_q != '0);
            idx_q       <= '0;
         end else if (bit_vld_i) begin
            sr_q <= sr_nxt;
            if (last) begin
               byte_vld_o <= 1'b1;
               byte_o     <= sr_nxt;
               sop_o      <= first_q;
               first_q    <= 1'b0;
               idx_q      <= '0;
            end else begin
               idx_q <= idx_q + BW'(1);
            end
         end
      end
   end

   // R8
   byte_eop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(byte_vld_o && eop_o));
   // R5
   sop_with_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sop_o |-> byte_vld_o);
endmodule

// File: rtl/usb_sync_rx.sv
module usb_sync_rx #(
   parameter int IDLE_MIN  = 2,
   parameter int MIN_ALT   = 3,
   parameter int STUFF_RUN = 6,
   parameter int DATA_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sym_en_i,
   input  logic [1:0]        sym_i,
   output logic              byte_vld_o,
   output logic [DATA_W-1:0] byte_o,
   output logic              byte_sop_o,
   output logic              eop_o,
   output logic              err_align_o,
   output logic              err_stuff_o
);
   import usb_rx_pkg::*;

   rx_mode_e mode_q;
   logic     se0_q;
   logic     is_se0, hit, rx_en, data_en, end_req;
   logic     bit_vld, bit_val, stuff_err;

   assign is_se0  = (sym_i[1] == sym_i[0]);
   assign rx_en   = sym_en_i && (mode_q == MODE_RECV);
   assign data_en = rx_en && !is_se0;
   assign end_req = rx_en && is_se0 && se0_q;

   usb_sync_hunt #(.IDLE_MIN(IDLE_MIN), .MIN_ALT(MIN_ALT)) hunt_i (
      .clk   (clk),
      .rst_n (rst_n),
      .arm_i (mode_q == MODE_HUNT),
      .en_i  (sym_en_i),
      .sym_i (sym_i),
      .hit_o (hit)
   );

   usb_nrzi_unstuff #(.STUFF_RUN(STUFF_RUN)) dec_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (hit),
      .en_i        (data_en),
      .level_i     (sym_i == SYM_K),
      .bit_vld_o   (bit_vld),
      .bit_o       (bit_val),
      .stuff_err_o (stuff_err)
   );

   usb_byte_pack #(.DATA_W(DATA_W), .LSB_FIRST(1'b1)) pack_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (hit),
      .bit_vld_i   (bit_vld),
      .bit_i       (bit_val),
      .end_i       (end_req),
      .abort_i     (stuff_err),
      .byte_vld_o  (byte_vld_o),
      .byte_o      (byte_o),
      .sop_o       (byte_sop_o),
      .eop_o       (eop_o),
      .err_align_o (err_align_o),
      .err_stuff_o (err_stuff_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_HUNT;
         se0_q  <= 1'b0;
      end else if (hit) begin
         mode_q <= MODE_RECV;
         se0_q  <= 1'b0;
      end else if (rx_en) begin
         if (end_req || stuff_err) begin
            mode_q <= MODE_HUNT;
            se0_q  <= 1'b0;
         end else begin
            se0_q <= is_se0;
         end
      end
   end

   // R7
   stuff_to_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_stuff_o |-> (mode_q == MODE_HUNT));
   // R9
   eop_to_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eop_o |-> (mode_q == MODE_HUNT));
   // R5
   byte_in_recv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld_o |-> (mode_q == MODE_RECV));
   // R1
   enter_on_k_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mode_q == MODE_RECV) |-> $past(sym_en_i && sym_i == SYM_K));
endmodule

// File: tb/usb_sync_rx_tb.sv
`timescale 1ns/1ps
module usb_sync_rx_tb_top;
   localparam logic [1:0] TJ = 2'b01;
   localparam logic [1:0] TK = 2'b10;
   localparam logic [1:0] T0 = 2'b00;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sym_en = 1'b0;
   logic [1:0] sym = TJ;
   logic       byte_vld, byte_sop, eop, err_align, err_stuff;
   logic [7:0] byte_d;

   int total = 0;
   int bad = 0;
   int seen = 0;
   bit done = 1'b0;

   logic [12:0] exp_q[$];
   string       tag_q[$];
   logic        txb[$];

   always #10 clk = ~clk;

   usb_sync_rx dut_i (
      .clk(clk), .rst_n(rst_n), .sym_en_i(sym_en), .sym_i(sym),
      .byte_vld_o(byte_vld), .byte_o(byte_d), .byte_sop_o(byte_sop),
      .eop_o(eop), .err_align_o(err_align), .err_stuff_o(err_stuff)
   );

   // event vector: {vld, sop, eop, align, stuff, data}
   function automatic logic [12:0] ev_byte(input logic [7:0] d, input logic s);
      return {1'b1, s, 3'b000, d};
   endfunction

   function automatic logic [12:0] ev_eop(input logic al);
      return {2'b00, 1'b1, al, 1'b0, 8'h00};
   endfunction

   task automatic expect_ev(input logic [12:0] e, input string t);
      exp_q.push_back(e);
      tag_q.push_back(t);
   endtask

   task automatic check(input string t, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", t, act, exp);
      end
   endtask

   // monitor: pops the scoreboard as results appear
   always @(negedge clk) begin
      if (rst_n && (byte_vld || eop || err_align || err_stuff)) begin
         logic [12:0] obs;
         obs = {byte_vld, byte_sop && byte_vld, eop, err_align, err_stuff,
                byte_vld ? byte_d : 8'h00};
         seen++;
         total++;
         if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL R3 unexpected event act=%h exp=none", obs);
         end else begin
            logic [12:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (obs !== e) begin
               bad++;
               $display("FAIL %s act=%h exp=%h", t, obs, e);
            end
         end
      end
   end

   task automatic send_sym(input logic [1:0] s);
      @(negedge clk);
      sym_en = 1'b1;
      sym    = s;
      @(negedge clk);
      sym_en = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) send_sym(TJ);
   endtask

   task automatic pre_full();
      send_sym(TK); send_sym(TJ); send_sym(TK); send_sym(TJ);
      send_sym(TK); send_sym(TJ); send_sym(TK); send_sym(TK);
   endtask

   task automatic pre_short();
      send_sym(TK); send_sym(TJ); send_sym(TK); send_sym(TK);
   endtask

   task automatic push_byte(input logic [7:0] b);
      for (int i = 0; i < 8; i++) txb.push_back(b[i]);
   endtask

   // NRZI transmitter starting from the anchor K
   task automatic send_bits(input bit do_stuff);
      logic lvl;
      int   ones;
      lvl  = 1'b1;
      ones = 0;
      while (txb.size() > 0) begin
         logic b;
         b = txb.pop_front();
         if (b) ones++;
         else begin lvl = ~lvl; ones = 0; end
         send_sym(lvl ? TK : TJ);
         if (do_stuff && ones == 6) begin
            lvl  = ~lvl;
            ones = 0;
            send_sym(lvl ? TK : TJ);
         end
      end
   endtask

   task automatic end_pkt();
      send_sym(T0); send_sym(T0); send_sym(TJ);
   endtask

   task automatic drain(input string t);
      repeat (6) @(negedge clk);
      check(t, exp_q.size(), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog act=running exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int s0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R5 reset state: no strobes, byte register cleared
      check("R5 reset", {byte_vld, byte_sop, eop, err_align, err_stuff, byte_d}, 0);

      // R1 R4 R5 R8: full preamble, two bytes
      expect_ev(ev_byte(8'hA5, 1'b1), "R1 first byte after preamble");
      expect_ev(ev_byte(8'h3C, 1'b0), "R5 second byte no sop");
      expect_ev(ev_eop(1'b0), "R8 clean end");
      idle(4); pre_full(); push_byte(8'hA5); push_byte(8'h3C); send_bits(1'b1); end_pkt();
      drain("R1 queue empty");

      // R6 R4: runs of ones with stuffed zeros, then all transitions
      expect_ev(ev_byte(8'hFF, 1'b1), "R6 stuffed byte 1");
      expect_ev(ev_byte(8'hFF, 1'b0), "R6 stuffed byte 2");
      expect_ev(ev_byte(8'h00, 1'b0), "R4 all-zero byte");
      expect_ev(ev_byte(8'h7E, 1'b0), "R6 byte after stuffing");
      expect_ev(ev_eop(1'b0), "R8 end after stuffed");
      idle(3); pre_full();
      push_byte(8'hFF); push_byte(8'hFF); push_byte(8'h00); push_byte(8'h7E);
      send_bits(1'b1); end_pkt();
      drain("R6 queue empty");

      // R2: shortened preamble
      expect_ev(ev_byte(8'h81, 1'b1), "R2 short preamble byte");
      expect_ev(ev_eop(1'b0), "R2 short preamble end");
      idle(2); pre_short(); push_byte(8'h81); send_bits(1'b1); end_pkt();
      drain("R2 queue empty");

      // R3: preambles that must be rejected
      s0 = seen;
      send_sym(T0); send_sym(T0); pre_full(); send_sym(T0); send_sym(T0);
      idle(3); send_sym(TK); send_sym(TK); send_sym(T0); send_sym(T0);
      idle(3); send_sym(TK); send_sym(TJ); send_sym(TJ); send_sym(T0); send_sym(T0);
      idle(2);
      repeat (6) @(negedge clk);
      check("R3 no events on rejected preambles", seen - s0, 0);

      // R8: partial byte at end
      expect_ev(ev_byte(8'h5A, 1'b1), "R8 byte before partial");
      expect_ev(ev_eop(1'b1), "R8 alignment error");
      idle(3); pre_full(); push_byte(8'h5A);
      txb.push_back(1'b1); txb.push_back(1'b0); txb.push_back(1'b1);
      send_bits(1'b1); end_pkt();
      drain("R8 queue empty");

      // R7: seven ones with no stuffed zero
      expect_ev({5'b00001, 8'h00}, "R7 stuff error");
      idle(3); pre_full(); push_byte(8'h7F); send_bits(1'b0); end_pkt();
      drain("R7 queue empty");

      // R9: next packet after error is received normally
      expect_ev(ev_byte(8'hC3, 1'b1), "R9 byte after error");
      expect_ev(ev_byte(8'h12, 1'b0), "R9 second byte");
      expect_ev(ev_eop(1'b0), "R9 end after recovery");
      idle(2); pre_full(); push_byte(8'hC3); push_byte(8'h12); send_bits(1'b1); end_pkt();
      drain("R9 queue empty");

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule